// File: doc/BRIEF.md
# NAND Bank Select and Strobe Front End

This block connects a simple memory-mapped bus to as many as four external NAND banks that share one data bus and one set of latch and strobe lines. A small register space holds a bank control word and a status word. The control word gives each bank its own pair of bits: an enable and a chip-assert. A bank's active-low chip enable drops only when both of its bits are set. A separate window space carries the NAND traffic.

A bus write into the window becomes one NAND write cycle, and a bus read becomes one NAND read cycle. Two offset bits inside the window choose what the cycle latches into the device: a command, an address or data. The strobe stays low for a fixed number of clocks, set by a parameter, and the bus handshake is held back until the strobe has risen again. The device ready/busy line passes through a two-flop synchroniser and can then be read from the status word.

Bus protocol: the master holds `bus_valid` and its request fields stable until it sees `bus_ready` high for one cycle, and drops `bus_valid` in the cycle that follows. A request that is present while the block is idle is accepted on the next rising clock edge.

State machine: the states are `ST_IDLE`, `ST_STROBE` and `ST_DONE`.
- `ST_IDLE` to `ST_STROBE`: a window access is accepted.
- `ST_IDLE` to `ST_DONE`: a register access is accepted.
- `ST_STROBE` to `ST_DONE`: the strobe counter reaches zero.
- `ST_DONE` to `ST_IDLE`: always, after one cycle.

Top module: `nand_bank_frontend`

## Requirements
- R1: `bus_addr[17]`=1 selects register space. Offset 0 is the control word and offset 4 is the status word. The control word holds bank n's enable at bit 2n and its chip-assert at bit 2n+1, and it reads back exactly the value last written.
- R2: `nand_ce_n[n]` is low exactly when bank n has both its enable bit and its assert bit set. It changes one clock after the control write is accepted.
- R3: Writing zero to the control word disables every bank and releases every chip enable. The control word then reads back as 0.
- R4: Clearing all assert bits (the bits of mask 0xAA) releases every chip enable and leaves the enable bits unchanged in the read-back value.
- R5: A window access (`bus_addr[17]`=0) with offset bit 15 set and bit 16 clear is a command cycle. `nand_cle` is high and `nand_ale` is low during the strobe.
- R6: A window access with offset bit 16 set and bit 15 clear is an address cycle. `nand_ale` is high and `nand_cle` is low during the strobe.
- R7: Any other window offset, including one with both bit 15 and bit 16 set, is a data cycle, with `nand_cle` and `nand_ale` both low.
- R8: A window write holds `nand_we_n` low for exactly STROBE_CYC (default 3) clocks, with `nand_dq_out` equal to the low byte written and `nand_dq_oe` high. `nand_re_n` stays high. `bus_ready` is raised STROBE_CYC+1 edges after acceptance.
- R9: A window read holds `nand_re_n` low for STROBE_CYC clocks with `nand_dq_oe` low. It returns `nand_dq_in` as sampled at the last strobe edge, in `bus_rdata` together with `bus_ready`.
- R10: Status bit 0 shows `nand_rb` (1 = ready) after two flops, and the other status bits read 0. A read accepted on the second edge after a change of `nand_rb` still returns the old level.
- R11: A register access raises `bus_ready` one edge after acceptance, with no strobe and with `nand_cle` and `nand_ale` low.
- R12: `bus_ready` is a single-cycle pulse. `nand_cle` and `nand_ale` are never high together, and `nand_we_n` and `nand_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 18 | Bit 17 selects register space; bits 16:0 are the offset |
| bus_wdata | input | 8 | Write data |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 8 | Read data, valid with bus_ready |
| nand_ce_n | output | 4 | Per-bank chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data driven to the devices |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Data returned by the devices |
| nand_rb | input | 1 | Ready/busy, high when ready |

## Verification
A register access completes one edge after acceptance. A window access completes STROBE_CYC+1 edges after acceptance, and chip enables follow a control write by one edge. The bench drives every input on a falling edge and then steps falling edge by falling edge until it sees `bus_ready`. It counts the edges this takes and compares the count with the expected latency. At each of those falling edges it also counts the cycles in which each strobe is low and records the latch lines and data bus seen during the strobe. The ready/busy latency is checked by issuing a status read immediately after `nand_rb` changes, which must return the old level, and then a later read, which must return the new one.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
    typedef enum logic [1:0] {
        CYC_DATA = 2'd0,
        CYC_CMD  = 2'd1,
        CYC_ADDR = 2'd2
    } cyc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_DONE   = 2'd2
    } fsm_state_e;
endpackage

// File: rtl/nfe_ctrl_reg.sv
module nfe_ctrl_reg #(
    parameter int NUM_BANKS = 4,
    localparam int CTRL_W = 2 * NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [NUM_BANKS-1:0] ce_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wr_data;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign ce_n[b] = ~(ctrl_q[2*b] & ctrl_q[2*b+1]);
    end
endmodule

// File: rtl/nfe_win_decode.sv
module nfe_win_decode
    import nfe_pkg::*;
(
    input  logic      cmd_bit,
    input  logic      adr_bit,
    output cyc_kind_e kind
);
    always_comb begin
        unique case ({adr_bit, cmd_bit})
            2'b01:   kind = CYC_CMD;
            2'b10:   kind = CYC_ADDR;
            default: kind = CYC_DATA;
        endcase
    end
endmodule

// File: rtl/nfe_rb_sync.sv
module nfe_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pipe <= '0;
        else
            pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/nand_bank_frontend.sv
module nand_bank_frontend
    import nfe_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int STROBE_CYC = 3,
    parameter int CMD_BIT    = 15,
    parameter int ALE_BIT    = 16,
    localparam int OFF_W     = ALE_BIT + 1,
    localparam int ADDR_W    = OFF_W + 1,
    localparam int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 bus_ready,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_BANKS-1:0] nand_ce_n,
    output logic                 nand_cle,
    output logic                 nand_ale,
    output logic                 nand_we_n,
    output logic                 nand_re_n,
    output logic [DATA_W-1:0]    nand_dq_out,
    output logic                 nand_dq_oe,
    input  logic [DATA_W-1:0]    nand_dq_in,
    input  logic                 nand_rb
);
    localparam int CTRL_W = 2 * NUM_BANKS;
    localparam int CNT_W  = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
    localparam logic [OFF_W-1:0] CTRL_OFF = OFF_W'(0);
    localparam logic [OFF_W-1:0] STAT_OFF = OFF_W'(4);

    fsm_state_e       state, state_nx;
    cyc_kind_e        win_kind, kind_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_q, win_q;
    logic [DATA_W-1:0] dq_q, rdata_q, reg_rd;
    logic [CTRL_W-1:0] ctrl_q;
    logic             rb_s;
    logic             accept, is_reg, ctrl_wr;
    logic [OFF_W-1:0] off;

    assign off     = bus_addr[OFF_W-1:0];
    assign is_reg  = bus_addr[ADDR_W-1];
    assign accept  = (state == ST_IDLE) && bus_valid;
    assign ctrl_wr = accept && is_reg && bus_write && (off == CTRL_OFF);

    nfe_ctrl_reg #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_wr),
        .wr_data(bus_wdata[CTRL_W-1:0]),
        .ctrl_q (ctrl_q),
        .ce_n   (nand_ce_n)
    );

    nfe_win_decode u_dec (
        .cmd_bit(bus_addr[CMD_BIT]),
        .adr_bit(bus_addr[ALE_BIT]),
        .kind   (win_kind)
    );

    nfe_rb_sync #(.STAGES(2)) u_rb (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (nand_rb),
        .q    (rb_s)
    );

    always_comb begin
        reg_rd = '0;
        if (off == CTRL_OFF)
            reg_rd = DATA_W'(ctrl_q);
        else if (off == STAT_OFF)
            reg_rd = DATA_W'(rb_s);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = is_reg ? ST_DONE : ST_STROBE;
            ST_STROBE: if (cnt_q == '0) state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // per-access latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            kind_q  <= CYC_DATA;
            wr_q    <= 1'b0;
            win_q   <= 1'b0;
            dq_q    <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            cnt_q  <= CNT_W'(STROBE_CYC - 1);
            kind_q <= is_reg ? CYC_DATA : win_kind;
            wr_q   <= bus_write;
            win_q  <= !is_reg;
            dq_q   <= bus_wdata;
            if (is_reg && !bus_write)
                rdata_q <= reg_rd;
        end else if (state == ST_STROBE) begin
            if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            else if (!wr_q)
                rdata_q <= nand_dq_in;
        end
    end

    // outputs
    always_comb begin
        nand_we_n   = 1'b1;
        nand_re_n   = 1'b1;
        nand_cle    = 1'b0;
        nand_ale    = 1'b0;
        nand_dq_oe  = 1'b0;
        nand_dq_out = dq_q;
        bus_ready   = 1'b0;
        bus_rdata   = rdata_q;
        unique case (state)
            ST_IDLE: ;
            ST_STROBE: begin
                nand_we_n  = !wr_q;
                nand_re_n  = wr_q;
                nand_cle   = (kind_q == CYC_CMD);
                nand_ale   = (kind_q == CYC_ADDR);
                nand_dq_oe = wr_q;
            end
            ST_DONE: begin
                nand_cle   = win_q && (kind_q == CYC_CMD);
                nand_ale   = win_q && (kind_q == CYC_ADDR);
                nand_dq_oe = win_q && wr_q;
                bus_ready  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nfe_checker.sv
module nfe_checker #(
    parameter int NUM_BANKS  = 4,
    parameter int STROBE_CYC = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_ready,
    input logic                 nand_cle,
    input logic                 nand_ale,
    input logic                 nand_we_n,
    input logic                 nand_re_n,
    input logic [NUM_BANKS-1:0] nand_ce_n,
    input logic [7:0]           nand_dq_out,
    input logic                 ctrl_wr,
    input logic [7:0]           bus_wdata
);
    logic strobe_lo;
    int   run_len;

    assign strobe_lo = !nand_we_n || !nand_re_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_len <= 0;
        else if (strobe_lo)
            run_len <= run_len + 1;
        else
            run_len <= 0;
    end

    a_r12_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    a_r12_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    a_r3_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata == 8'h00) |=> (&nand_ce_n));

    a_r8_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_lo) |-> (run_len == STROBE_CYC));

    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_lo && $past(strobe_lo)) |->
            ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_dq_out)));
endmodule

bind nand_bank_frontend nfe_checker #(
    .NUM_BANKS (NUM_BANKS),
    .STROBE_CYC(STROBE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ready  (bus_ready),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_ce_n  (nand_ce_n),
    .nand_dq_out(nand_dq_out),
    .ctrl_wr    (ctrl_wr),
    .bus_wdata  (bus_wdata)
);

// File: tb/tb_nand_bank_frontend.sv
module tb_nand_bank_frontend;
    localparam int STROBE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [17:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_ready;
    logic [7:0]  bus_rdata;
    logic [3:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = '0;
    logic        nand_rb = 1'b0;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    nand_bank_frontend #(.NUM_BANKS(4), .STROBE_CYC(STROBE)) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_ce(input logic [7:0] c);
        logic [3:0] r;
        for (int b = 0; b < 4; b++) r[b] = !(c[2*b] && c[2*b+1]);
        return r;
    endfunction

    // 0 data, 1 command, 2 address
    function automatic int exp_kind(input logic [16:0] off);
        if (off[15] && !off[16]) return 1;
        if (off[16] && !off[15]) return 2;
        return 0;
    endfunction

    task automatic bus_op(input logic wr, input logic [17:0] a, input logic [7:0] wd,
                          output logic [7:0] rd, output int n, output int we_lo,
                          output int re_lo, output logic cle_s, output logic ale_s,
                          output logic [7:0] dq_s, output logic oe_s);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = wd;
        n = 0; we_lo = 0; re_lo = 0; cle_s = 0; ale_s = 0; dq_s = 0; oe_s = 0;
        while (n < 64) begin
            @(negedge clk);
            n++;
            if (!nand_we_n) begin
                we_lo++; cle_s = nand_cle; ale_s = nand_ale;
                dq_s = nand_dq_out; oe_s = nand_dq_oe;
            end
            if (!nand_re_n) begin
                re_lo++; cle_s = nand_cle; ale_s = nand_ale; oe_s = nand_dq_oe;
            end
            if (bus_ready) break;
        end
        rd = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic reg_op(input logic wr, input logic [16:0] off, input logic [7:0] wd,
                          output logic [7:0] rd);
        int n, wl, rl; logic c, a, o; logic [7:0] d;
        bus_op(wr, {1'b1, off}, wd, rd, n, wl, rl, c, a, d, o);
        chk(n == 1 && wl == 0 && rl == 0 && !c && !a, "R11 reg access latency", n, 1);
    endtask

    task automatic ctrl_set(input logic [7:0] v, input string req);
        logic [7:0] rd;
        reg_op(1'b1, 17'd0, v, rd);
        chk(nand_ce_n == exp_ce(v), req, nand_ce_n, exp_ce(v));
        reg_op(1'b0, 17'd0, 8'h00, rd);
        chk(rd == v, "R1 control read-back", rd, v);
    endtask

    task automatic win_op(input logic wr, input logic [16:0] off, input logic [7:0] wd);
        int n, wl, rl, k; logic c, a, o; logic [7:0] d, rd, din;
        din = 8'($urandom);
        nand_dq_in = din;
        k = exp_kind(off);
        bus_op(wr, {1'b0, off}, wd, rd, n, wl, rl, c, a, d, o);
        chk(n == STROBE + 1, "R8 window latency", n, STROBE + 1);
        if (k == 1) chk(c && !a, "R5 command latch", {c, a}, 2);
        else if (k == 2) chk(!c && a, "R6 address latch", {c, a}, 1);
        else chk(!c && !a, "R7 data cycle latches low", {c, a}, 0);
        if (wr) begin
            chk(wl == STROBE && rl == 0, "R8 write strobe length", wl, STROBE);
            chk(d == wd && o, "R8 write data driven", d, wd);
        end else begin
            chk(rl == STROBE && wl == 0, "R9 read strobe length", rl, STROBE);
            chk(rd == din && !o, "R9 read data", rd, din);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(nand_ce_n == 4'hF && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !bus_ready,
            "R2 reset state", nand_ce_n, 4'hF);

        // directed control cases
        ctrl_set(8'h03, "R2 bank0 selected");
        ctrl_set(8'h80, "R2 assert without enable");
        ctrl_set(8'h40, "R2 enable without assert");
        ctrl_set(8'hFF, "R2 all banks selected");
        ctrl_set(8'hFF & 8'h55, "R4 deselect keeps enables");
        ctrl_set(8'hFF, "R2 reselect");
        ctrl_set(8'h00, "R3 write zero releases all");

        // directed window cases
        ctrl_set(8'h0C, "R2 bank1 selected");
        win_op(1'b1, 17'h08000, 8'h70);
        win_op(1'b1, 17'h10000, 8'h12);
        win_op(1'b1, 17'h18000, 8'hA5);
        win_op(1'b1, 17'h00123, 8'h3C);
        win_op(1'b0, 17'h00000, 8'h00);
        win_op(1'b0, 17'h08000, 8'h00);

        // ready/busy synchroniser
        nand_rb = 1'b1;
        reg_op(1'b0, 17'd4, 8'h00, rd);
        chk(rd == 8'h00, "R10 ready not yet visible", rd, 0);
        reg_op(1'b0, 17'd4, 8'h00, rd);
        chk(rd == 8'h01, "R10 ready visible", rd, 1);
        nand_rb = 1'b0;
        reg_op(1'b0, 17'd4, 8'h00, rd);
        chk(rd == 8'h01, "R10 busy not yet visible", rd, 1);
        reg_op(1'b0, 17'd4, 8'h00, rd);
        chk(rd == 8'h00, "R10 busy visible", rd, 0);

        // ignored status write
        reg_op(1'b1, 17'd4, 8'hFF, rd);
        reg_op(1'b0, 17'd0, 8'h00, rd);
        chk(rd == 8'h0C, "R1 status write leaves control", rd, 8'h0C);

        // random mix
        for (int i = 0; i < 60; i++) begin
            int sel;
            logic [16:0] off;
            sel = int'($urandom % 5);
            if (sel == 4) begin
                ctrl_set(8'($urandom), "R2 random control");
            end else begin
                case (sel)
                    0: off = 17'h08000;
                    1: off = 17'h10000;
                    2: off = 17'h18000;
                    default: off = 17'($urandom);
                endcase
                win_op(1'($urandom), off, 8'($urandom));
            end
        end

        ctrl_set(8'h00, "R3 final clear");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule